// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block is a 64-bit time base driven by a slow clock that nominally runs at 32768 Hz. It has two 32-bit parts: whole seconds, and a fraction of a second in which the value V stands for V/2^32 s. For example, 0x4000_0000 is a quarter second and 0xC000_0000 is three quarters. On every enabled cycle the counter adds a programmable 24-bit step. The upper 18 bits of the step go into the low end of the fraction. The lower 6 bits collect in an internal 6-bit remainder register, and when that register overflows it adds one extra unit to the fraction sum. This lets software trim the rate for a slow clock that is off its nominal frequency.

The block also provides:
- a run enable;
- a clear request that stays pending for one cycle and then empties itself;
- a seconds read strobe that freezes a copy of the fraction, so that a later fraction read is consistent with the seconds value;
- a 32-bit compact time word;
- a reference tap taken from fraction bit 19;
- an output that toggles every cycle.

Top module: `rtc_frac_counter`

## Requirements
- R1: After the synchronous reset, seconds, fraction, frozen fraction, toggle output and clear-busy flag are all 0, the internal remainder is 0, and the step is 0x800000.
- R2: On each clock edge where the counter is enabled and no clear is pending, the fraction grows by step bits [23:6] plus the remainder carry. The carry out of the 32-bit fraction adds one to the seconds.
- R3: Step bits [5:0] add into the 6-bit remainder on every counting edge. Its overflow adds exactly one to the fraction, so a step of 0x000001 raises the fraction by 1 every 64 counting edges.
- R4: With the reset step 0x800000, exactly 32768 counting edges starting from zero give seconds = 1 and fraction = 0.
- R5: While the run enable is 0 and no clear is pending, seconds and fraction hold their values.
- R6: A pulse on `clr_wr` sets `clr_busy_o` at the next edge. At the edge after that, seconds, fraction and the internal remainder become 0 and `clr_busy_o` returns to 0.
- R7: A pulse on `rd_sec` copies the fraction value present in that cycle into `snap_o`. The copy holds until the next pulse.
- R8: `ctime_o` carries seconds bits [15:0] in bits [31:16] and fraction bits [31:16] in bits [15:0].
- R9: `ref4k_o` equals fraction bit 19 when both `tap_en` and `run_en` are 1, and is 0 otherwise.
- R10: While `tog_en` is 1, `tog_o` inverts on every edge. An edge where `tog_en` is 0 drives it to 0.
- R11: A pulse on `inc_wr` loads `inc_data` as the step. The new step takes effect from the following counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter enable |
| clr_wr | input | 1 | Clear request pulse |
| inc_wr | input | 1 | Step load strobe |
| inc_data | input | 24 | New step value |
| rd_sec | input | 1 | Seconds read strobe, freezes the fraction |
| tap_en | input | 1 | Reference tap enable |
| tog_en | input | 1 | Toggle output enable |
| sec_o | output | 32 | Seconds count |
| frac_o | output | 32 | Live fraction |
| snap_o | output | 32 | Fraction frozen at the last seconds read |
| ctime_o | output | 32 | Compact time word |
| ref4k_o | output | 1 | Fraction bit 19 tap |
| tog_o | output | 1 | Half-rate toggle |
| clr_busy_o | output | 1 | Clear request pending |

## Verification
The assertions check four properties on every cycle:
- the counter holds while it is disabled;
- a pending clear empties itself and leaves zero time behind;
- the frozen fraction matches the fraction seen at the read strobe;
- the tap and toggle outputs are forced to 0 while disabled.

The exact arithmetic is shown only by the bench scenarios, whose reference model predicts every value cycle by cycle. These scenarios cover the 18-bit step alignment, the remainder carry with a step of 1, the exact one-second rollover after 32768 default steps, a clear that also empties the remainder, and step reloads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned SEC_BITS  = 32;
  localparam int unsigned FRAC_BITS = 32;
  localparam int unsigned STEP_BITS = 24;
  localparam int unsigned REM_BITS  = 6;
  localparam int unsigned TAP_POS   = 19;
  localparam int unsigned VIEW_HALF = 16;
  // 2^38 / 32768: one nominal slow-clock period in 2^-38 s units
  localparam logic [STEP_BITS-1:0] STEP_NOMINAL = 24'h80_0000;
endpackage

// File: rtl/rtc_ctl.sv
// Clear request (pending for one cycle) and the step register.
module rtc_ctl #(
  parameter int unsigned  INC_W   = rtc_pkg::STEP_BITS,
  parameter logic [INC_W-1:0] INC_RST = rtc_pkg::STEP_NOMINAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_wr,
  input  logic             inc_wr,
  input  logic [INC_W-1:0] inc_data,
  output logic             clr_pend,
  output logic [INC_W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_pend <= 1'b0;
      step_q   <= INC_RST;
    end else begin
      // a pending clear is consumed on the edge that performs it
      clr_pend <= clr_wr;
      if (inc_wr) step_q <= inc_data;
    end
  end
endmodule

// File: rtl/rtc_accum.sv
// Seconds/fraction accumulator with a hidden low-order remainder.
module rtc_accum #(
  parameter int unsigned SEC_W  = rtc_pkg::SEC_BITS,
  parameter int unsigned FRAC_W = rtc_pkg::FRAC_BITS,
  parameter int unsigned INC_W  = rtc_pkg::STEP_BITS,
  parameter int unsigned HID_W  = rtc_pkg::REM_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clr,
  input  logic [INC_W-1:0]  step,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q
);
  localparam int unsigned ALIGN_W = INC_W - HID_W;

  logic [HID_W-1:0]  rem_q;
  logic [HID_W:0]    rem_sum;
  logic [FRAC_W:0]   frac_sum;
  logic [SEC_W-1:0]  sec_sum;

  always_comb begin
    rem_sum  = {1'b0, rem_q} + {1'b0, step[HID_W-1:0]};
    frac_sum = {1'b0, frac_q}
             + {{(FRAC_W + 1 - ALIGN_W){1'b0}}, step[INC_W-1:HID_W]}
             + {{FRAC_W{1'b0}}, rem_sum[HID_W]};
    sec_sum  = sec_q + {{(SEC_W - 1){1'b0}}, frac_sum[FRAC_W]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem_q  <= '0;
      frac_q <= '0;
      sec_q  <= '0;
    end else if (run) begin
      rem_q  <= rem_sum[HID_W-1:0];
      frac_q <= frac_sum[FRAC_W-1:0];
      sec_q  <= sec_sum;
    end
  end
endmodule

// File: rtl/rtc_snap.sv
// Fraction copy taken when the seconds are read.
module rtc_snap #(
  parameter int unsigned FRAC_W = rtc_pkg::FRAC_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (rst)     snap_q <= '0;
    else if (rd) snap_q <= frac;
  end
endmodule

// File: rtl/rtc_outs.sv
// Toggle output and gated reference tap.
module rtc_outs #(
  parameter int unsigned FRAC_W = rtc_pkg::FRAC_BITS,
  parameter int unsigned TAP    = rtc_pkg::TAP_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tap_en,
  input  logic              tog_en,
  input  logic [FRAC_W-1:0] frac,
  output logic              tap_o,
  output logic              tog_q
);
  always_ff @(posedge clk) begin
    if (rst || !tog_en) tog_q <= 1'b0;
    else                tog_q <= ~tog_q;
  end

  assign tap_o = frac[TAP] & tap_en & run;
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int unsigned  SEC_W   = rtc_pkg::SEC_BITS,
  parameter int unsigned  FRAC_W  = rtc_pkg::FRAC_BITS,
  parameter int unsigned  INC_W   = rtc_pkg::STEP_BITS,
  parameter int unsigned  HID_W   = rtc_pkg::REM_BITS,
  parameter int unsigned  TAP     = rtc_pkg::TAP_POS,
  parameter int unsigned  HALF_W  = rtc_pkg::VIEW_HALF,
  parameter logic [INC_W-1:0] INC_RST = rtc_pkg::STEP_NOMINAL
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic                clr_wr,
  input  logic                inc_wr,
  input  logic [INC_W-1:0]    inc_data,
  input  logic                rd_sec,
  input  logic                tap_en,
  input  logic                tog_en,
  output logic [SEC_W-1:0]    sec_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic [FRAC_W-1:0]   snap_o,
  output logic [2*HALF_W-1:0] ctime_o,
  output logic                ref4k_o,
  output logic                tog_o,
  output logic                clr_busy_o
);
  logic [INC_W-1:0] step;

  rtc_ctl #(.INC_W(INC_W), .INC_RST(INC_RST)) u_ctl (
    .clk(clk), .rst(rst), .clr_wr(clr_wr), .inc_wr(inc_wr),
    .inc_data(inc_data), .clr_pend(clr_busy_o), .step_q(step)
  );

  rtc_accum #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .HID_W(HID_W)) u_acc (
    .clk(clk), .rst(rst), .run(run_en), .clr(clr_busy_o), .step(step),
    .sec_q(sec_o), .frac_q(frac_o)
  );

  rtc_snap #(.FRAC_W(FRAC_W)) u_snap (
    .clk(clk), .rst(rst), .rd(rd_sec), .frac(frac_o), .snap_q(snap_o)
  );

  rtc_outs #(.FRAC_W(FRAC_W), .TAP(TAP)) u_outs (
    .clk(clk), .rst(rst), .run(run_en), .tap_en(tap_en), .tog_en(tog_en),
    .frac(frac_o), .tap_o(ref4k_o), .tog_q(tog_o)
  );

  assign ctime_o = {sec_o[HALF_W-1:0], frac_o[FRAC_W-1 -: HALF_W]};
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              clr_wr,
  input logic              rd_sec,
  input logic              tap_en,
  input logic              tog_en,
  input logic [SEC_W-1:0]  sec_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic [FRAC_W-1:0] snap_o,
  input logic              ref4k_o,
  input logic              tog_o,
  input logic              clr_busy_o
);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !clr_busy_o) |=> ($stable(sec_o) && $stable(frac_o)));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_busy_o && !clr_wr) |=> (sec_o == '0 && frac_o == '0 && !clr_busy_o));

  p_snap_r7: assert property (@(posedge clk) disable iff (rst)
    rd_sec |=> (snap_o == $past(frac_o)));

  p_tap_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!tap_en || !run_en) |-> !ref4k_o);

  p_tog_off_r10: assert property (@(posedge clk) disable iff (rst)
    !tog_en |=> !tog_o);

  p_tog_flip_r10: assert property (@(posedge clk) disable iff (rst)
    tog_en |=> (tog_o != $past(tog_o)));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .clr_wr(clr_wr), .rd_sec(rd_sec),
  .tap_en(tap_en), .tog_en(tog_en), .sec_o(sec_o), .frac_o(frac_o),
  .snap_o(snap_o), .ref4k_o(ref4k_o), .tog_o(tog_o), .clr_busy_o(clr_busy_o)
);

// File: tb/tb_rtc_frac_counter.sv
module tb_rtc_frac_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0, clr_wr = 1'b0, inc_wr = 1'b0, rd_sec = 1'b0;
  logic        tap_en = 1'b0, tog_en = 1'b0;
  logic [23:0] inc_data = '0;
  logic [31:0] sec_o, frac_o, snap_o, ctime_o;
  logic        ref4k_o, tog_o, clr_busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_frac_counter dut (
    .clk(clk), .rst(rst), .run_en(run_en), .clr_wr(clr_wr), .inc_wr(inc_wr),
    .inc_data(inc_data), .rd_sec(rd_sec), .tap_en(tap_en), .tog_en(tog_en),
    .sec_o(sec_o), .frac_o(frac_o), .snap_o(snap_o), .ctime_o(ctime_o),
    .ref4k_o(ref4k_o), .tog_o(tog_o), .clr_busy_o(clr_busy_o)
  );

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] frac;
    logic [31:0] snap;
    logic        tog;
    logic        busy;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic [31:0] m_sec = '0, m_frac = '0, m_snap = '0;
  logic [5:0]  m_rem = '0;
  logic [23:0] m_step = 24'h80_0000;
  logic        m_pend = 1'b0, m_tog = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: predict the state after each edge and queue it
  always @(posedge clk) begin
    exp_t e;
    logic [6:0]  rs;
    logic [32:0] fs;
    if (rst) begin
      m_sec = '0; m_frac = '0; m_snap = '0; m_rem = '0;
      m_step = 24'h80_0000; m_pend = 1'b0; m_tog = 1'b0;
    end else begin
      if (rd_sec) m_snap = m_frac;
      if (m_pend) begin
        m_sec = '0; m_frac = '0; m_rem = '0;
      end else if (run_en) begin
        rs = {1'b0, m_rem} + {1'b0, m_step[5:0]};
        fs = {1'b0, m_frac} + {15'd0, m_step[23:6]} + {32'd0, rs[6]};
        m_rem  = rs[5:0];
        m_frac = fs[31:0];
        m_sec  = m_sec + {31'd0, fs[32]};
      end
      m_pend = clr_wr;
      if (inc_wr) m_step = inc_data;
      m_tog = tog_en ? ~m_tog : 1'b0;
    end
    e.sec = m_sec; e.frac = m_frac; e.snap = m_snap; e.tog = m_tog; e.busy = m_pend;
    q.push_back(e);
  end

  // monitor: compare away from the edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0 && !done) begin
      e = q.pop_front();
      chk("R2 seconds", {32'd0, sec_o}, {32'd0, e.sec});
      chk("R2 fraction", {32'd0, frac_o}, {32'd0, e.frac});
      chk("R7 snapshot", {32'd0, snap_o}, {32'd0, e.snap});
      chk("R10 toggle", {63'd0, tog_o}, {63'd0, e.tog});
      chk("R6 busy", {63'd0, clr_busy_o}, {63'd0, e.busy});
      chk("R8 compact", {32'd0, ctime_o}, {32'd0, e.sec[15:0], e.frac[31:16]});
      chk("R9 tap", {63'd0, ref4k_o}, {63'd0, e.frac[19] & tap_en & run_en});
    end
  end

  task automatic step_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_clear();
    clr_wr = 1'b1; step_cyc(1);
    clr_wr = 1'b0;
    chk("R6 busy set", {63'd0, clr_busy_o}, 64'd1);
    step_cyc(1);
    chk("R6 busy clears", {63'd0, clr_busy_o}, 64'd0);
    chk("R6 cleared", {sec_o, frac_o}, 64'd0);
  endtask

  task automatic load_step(input logic [23:0] v);
    inc_wr = 1'b1; inc_data = v; step_cyc(1);
    inc_wr = 1'b0;
  endtask

  initial begin
    logic [31:0] seen;
    step_cyc(4);
    rst = 1'b0;
    step_cyc(1);
    chk("R1 reset time", {sec_o, frac_o}, 64'd0);
    chk("R1 reset snap/tog/busy", {snap_o, 29'd0, tog_o, clr_busy_o, ref4k_o}, 64'd0);

    // R4: exact second with the nominal step (also R1 reset step)
    run_en = 1'b1;
    step_cyc(32768);
    run_en = 1'b0;
    chk("R4 one second", {sec_o, frac_o}, {32'd1, 32'd0});

    // R5: hold while disabled
    step_cyc(10);
    chk("R5 hold", {sec_o, frac_o}, {32'd1, 32'd0});

    // R7: read latch while running
    run_en = 1'b1; step_cyc(5);
    seen = frac_o; rd_sec = 1'b1; step_cyc(1);
    rd_sec = 1'b0;
    step_cyc(7);
    chk("R7 snapshot held", {32'd0, snap_o}, {32'd0, seen});
    run_en = 1'b0;

    // R3 and hidden-remainder clear: dirty the remainder first
    load_step(24'h00_0001);
    run_en = 1'b1; step_cyc(30); run_en = 1'b0;
    do_clear();
    run_en = 1'b1; step_cyc(63);
    chk("R3 no carry before 64", {32'd0, frac_o}, 64'd0);
    step_cyc(1);
    run_en = 1'b0;
    chk("R3 carry at 64", {32'd0, frac_o}, 64'd1);

    // R11, R9, R10: large step with tap and toggle patterns
    load_step(24'hFF_FFFF);
    tap_en = 1'b1; tog_en = 1'b1; run_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step_cyc(37);
      run_en = ~run_en;
      if (i % 3 == 0) tap_en = ~tap_en;
      if (i % 4 == 0) tog_en = ~tog_en;
    end
    run_en = 1'b1;
    load_step(24'h12_3456);
    step_cyc(500);
    chk("R11 step applied", {32'd0, frac_o}, {32'd0, m_frac});

    // clear requested while running
    clr_wr = 1'b1; step_cyc(1); clr_wr = 1'b0;
    step_cyc(1);
    chk("R6 clear while running", {sec_o, frac_o}, 64'd0);
    step_cyc(20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule